// File: doc/BRIEF.md
# Predecoded Row Address Decoder

This block turns a row address into a one-hot vector of word-line enables, one line per row. It decodes in two levels. The address is cut into two-bit slices, and each slice is decoded on its own into a bundle of four lines with exactly one line high. Each word line is then a small AND that takes one line from every bundle. The common terms are built once, in the slice decoders, and the per-row gates stay narrow. When the address width is odd, the top single bit gets a bundle of two lines.

A global access enable gates every word line. A memory controller holds the enable low during precharge and raises it for the access phase. The address and the enable are captured on the rising clock edge. The word lines follow from the captured values one cycle later and stay steady for the whole cycle.

Top module: `row_predecoder`

## Requirements
- R1: While reset is asserted (rstN low), and in the first cycle after it, every word line is low.
- R2: If accessEn was low at the last rising edge, every word line is low for the following cycle, whatever the value of rowAddr.
- R3: If accessEn was high at the last rising edge, exactly one word line is high. Its index equals the rowAddr sampled at that edge, so wordLines equals 1 shifted left by that address.
- R4: The word lines change only in response to a rising edge. A new address or enable driven between edges leaves wordLines unchanged until the next edge.
- R5: Address bits [2g+1:2g] form slice g. Each slice selects one line of a one-of-four bundle, and every combination of slice values reaches its own word line.
- R6: When ADDR_W is odd, the top address bit alone forms the last slice, decoded one-of-two. Rows whose index has that bit set, such as the highest row, are reached correctly.
- R7: Addresses presented on consecutive edges with the enable held high each select their own word line in the next cycle, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rowAddr | input | ADDR_W | Row address, sampled at the rising edge |
| accessEn | input | 1 | Global word-line enable, sampled at the rising edge |
| wordLines | output | 2**ADDR_W | One-hot word-line enables |

## Verification
The single-bit slice that an odd width creates is the hardest case to reach from the ports. Only rows in the upper half of the address space show whether that slice's two lines are wired correctly. The bench uses a five-bit address for this reason. It sweeps every row, and it also drives addresses that set only the top bit together with different low slices, so that a fault in the single-bit slice cannot hide behind the two-bit slices. It also drives a new address between edges, which checks that the output waits for the edge.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic addrLoad;   // capture the row address at this edge
    logic wlOpen;     // word lines may open this cycle
  } rowdecStrobes_t;

  // Number of address slices: two bits each, last one may be a single bit
  function automatic int sliceCount(input int addrW);
    return (addrW + 1) / 2;
  endfunction
endpackage

// File: rtl/rowdec_slice.sv
module rowdec_slice #(
  parameter int SLICE_W = 2
) (
  input  logic [SLICE_W-1:0] sliceBits,
  output logic [3:0]         sliceLines
);
  generate
    if (SLICE_W == 2) begin : g_quad
      always_comb begin
        sliceLines[0] = ~sliceBits[1] & ~sliceBits[0];
        sliceLines[1] = ~sliceBits[1] &  sliceBits[0];
        sliceLines[2] =  sliceBits[1] & ~sliceBits[0];
        sliceLines[3] =  sliceBits[1] &  sliceBits[0];
      end
    end else begin : g_pair
      always_comb begin
        sliceLines[0] = ~sliceBits[0];
        sliceLines[1] =  sliceBits[0];
        sliceLines[3:2] = 2'b00;
      end
    end
  endgenerate
endmodule

// File: rtl/rowdec_ctrl.sv
module rowdec_ctrl
  import rowdec_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           accessEn,
  output rowdecStrobes_t strobes
);
  logic openQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) openQ <= 1'b0;
    else       openQ <= accessEn;
  end

  always_comb begin
    strobes.addrLoad = accessEn;
    strobes.wlOpen   = openQ;
  end
endmodule

// File: rtl/rowdec_datapath.sv
module rowdec_datapath
  import rowdec_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     rowAddr,
  input  rowdecStrobes_t        strobes,
  output logic [(1<<ADDR_W)-1:0] wordLines
);
  localparam int NUM_WL  = 1 << ADDR_W;
  localparam int NUM_GRP = sliceCount(ADDR_W);

  logic [ADDR_W-1:0] addrQ;
  logic [3:0]        bundle [NUM_GRP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 addrQ <= '0;
    else if (strobes.addrLoad) addrQ <= rowAddr;
  end

  // First level: one predecoder per address slice
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_slice
    localparam int LO = 2 * g;
    localparam int SW = ((ADDR_W - LO) >= 2) ? 2 : 1;
    rowdec_slice #(.SLICE_W(SW)) u_slice (
      .sliceBits (addrQ[LO +: SW]),
      .sliceLines(bundle[g])
    );

    // R5
    bundle_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $countones(bundle[g]) == 1);

    if (SW == 1) begin : g_oddChk
      // R6
      odd_slice_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
        bundle[g][3:2] == 2'b00);
    end
  end

  // Second level: each row ANDs one line from every bundle with the enable
  for (genvar w = 0; w < NUM_WL; w++) begin : g_row
    always_comb begin
      logic acc;
      acc = strobes.wlOpen;
      for (int g = 0; g < NUM_GRP; g++) begin
        acc = acc & bundle[g][2'((w >> (2 * g)) & 3)];
      end
      wordLines[w] = acc;
    end
  end

  // R2
  closed_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wlOpen |-> wordLines == '0);

  // R3
  single_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wlOpen |-> $countones(wordLines) == 1);
endmodule

// File: rtl/row_predecoder.sv
module row_predecoder
  import rowdec_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      rowAddr,
  input  logic                   accessEn,
  output logic [(1<<ADDR_W)-1:0] wordLines
);
  rowdecStrobes_t strobes;

  rowdec_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .accessEn(accessEn),
    .strobes (strobes)
  );

  rowdec_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rowAddr  (rowAddr),
    .strobes  (strobes),
    .wordLines(wordLines)
  );

  // R3
  addr_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(accessEn)) |-> wordLines[$past(rowAddr)]);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> wordLines == '0);
endmodule

// File: tb/row_predecoder_bench.sv
module row_predecoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] rowAddr = '0;
  logic          accessEn = 1'b0;
  logic [NW-1:0] wordLines;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  row_predecoder #(.ADDR_W(AW)) u_row_predecoder (
    .clk(clk), .rstN(rstN), .rowAddr(rowAddr),
    .accessEn(accessEn), .wordLines(wordLines)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expectLines(input string req, input logic [NW-1:0] exp);
    checks++;
    if (wordLines !== exp) begin
      fails++;
      $display("FAIL %s: wordLines=%h expected=%h", req, wordLines, exp);
    end
  endtask

  // drive after falling edge, sample after next rising edge settles
  task automatic cycle(input logic en, input logic [AW-1:0] a);
    @(negedge clk);
    accessEn = en;
    rowAddr  = a;
    @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    accessEn = 1'b1;
    rowAddr = 5'd7;
    repeat (2) @(posedge clk);
    #1;
    expectLines("R1 during reset", '0);
    @(negedge clk);
    rstN = 1'b1;
    accessEn = 1'b0;
    @(posedge clk);
    #1;
    expectLines("R1 after reset", '0);
  endtask

  task automatic testSweep();
    for (int a = 0; a < NW; a++) begin
      cycle(1'b1, AW'(a));
      expectLines("R3 R5 sweep", NW'(1) << a);
    end
  endtask

  task automatic testClosed();
    for (int a = 0; a < NW; a += 5) begin
      cycle(1'b0, AW'(a));
      expectLines("R2 enable low", '0);
    end
    cycle(1'b1, 5'd9);
    expectLines("R3 reopen", NW'(1) << 9);
    cycle(1'b0, 5'd9);
    expectLines("R2 close after open", '0);
  endtask

  task automatic testOddSlice();
    logic [AW-1:0] picks [5] = '{5'd16, 5'd17, 5'd22, 5'd27, 5'd31};
    for (int i = 0; i < 5; i++) begin
      cycle(1'b1, picks[i]);
      expectLines("R6 top slice", NW'(1) << picks[i]);
    end
  endtask

  task automatic testLatency();
    cycle(1'b1, 5'd3);
    expectLines("R4 setup", NW'(1) << 3);
    @(negedge clk);
    rowAddr = 5'd28;
    #1;
    expectLines("R4 mid-cycle address", NW'(1) << 3);
    accessEn = 1'b0;
    #1;
    expectLines("R4 mid-cycle enable", NW'(1) << 3);
    @(posedge clk);
    #1;
    expectLines("R4 after edge", '0);
  endtask

  task automatic testBackToBack();
    logic [AW-1:0] seq [6] = '{5'd0, 5'd31, 5'd1, 5'd30, 5'd10, 5'd21};
    for (int i = 0; i < 6; i++) begin
      cycle(1'b1, seq[i]);
      expectLines("R7 back to back", NW'(1) << seq[i]);
    end
  endtask

  initial begin
    testReset();
    testSweep();
    testClosed();
    testOddSlice();
    testLatency();
    testBackToBack();
    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule